// File: doc/BRIEF.md
# Floppy Controller Host Register Interface and Phase Sequencer

This block sits between a processor bus and the execution engine of a floppy disk controller. It decodes chip select, read and write strobes and one address bit into two host-visible locations: a read-only main status byte and a data port. Every command passes through three phases. In the command phase the host writes a fixed number of bytes, the first of which carries the opcode. Execution starts automatically after the last byte. In the result phase the host must read a fixed number of result bytes before another command is accepted.

The host paces itself on two status bits. A ready flag says the data port can take or give a byte. A direction flag says which way that byte moves. After each accepted byte the ready flag drops for at least one clock. The direction flag only changes while the ready flag is low, so a host that polls status never sees a half-changed handshake. Command bytes go to the execution engine on a parameter strobe with their index. Result bytes come back from the engine on `res_byte`, selected by `res_idx`. A terminal count input lets the host abandon a command that is being written or executed.

The sequencer states are IDLE (ready for an opcode), CMD (ready for a further parameter), CGAP (ready low after a command byte), EXEC (engine running), RGAP (ready low, direction set to output), RES (result byte available) and IGAP (ready low, direction back to input). The transitions are:
- IDLE to CGAP on a byte write.
- CMD to CGAP on a byte write, or CMD to IGAP on terminal count.
- CGAP to CMD while bytes remain.
- CGAP to EXEC after the last byte of a known opcode, or CGAP to RGAP after an unknown opcode.
- CGAP to IGAP on terminal count.
- EXEC to RGAP, or to IGAP when the opcode has no results, on completion or terminal count.
- RGAP to RES.
- RES to RGAP after a read that is not the last, or RES to IGAP after the last read.
- IGAP to IDLE.

Top module: `fdc_host_seq`

## Requirements
- R1: While `cs_n` is low, three accesses are legal: `rd_n` low with `a0`=0 reads the status byte, `rd_n` low with `a0`=1 reads the data port, and `wr_n` low with `a0`=1 writes the data port. Any other strobe combination changes nothing, and so does any strobe while `cs_n` is high.
- R2: After reset the status byte reads 0x80 OR the four `drv_seek` flags in bits 3..0. Bit 4 always reads 0.
- R3: Status bit 7 is the ready flag and bit 6 the direction flag (1 = block to host). Bit 5 is high exactly while executing with `dma_off`=1.
- R4: A data write is taken as a command byte only when ready=1 and direction=0. Each taken byte appears one clock later on `par_data` with `par_we` high for one clock, and `par_idx` counts 0, 1, 2 and so on within the command.
- R5: The ready flag is low in the clock after each accepted data write and after each consumed result byte.
- R6: The direction flag never changes while the ready flag stays high.
- R7: The opcode is bits 4..0 of the first byte. The command and result byte counts per opcode are: 0x06 9/7, 0x05 9/7, 0x0D 6/7, 0x0A 2/7, 0x03 3/0, 0x07 2/0, 0x0F 3/0, 0x08 1/2, 0x04 2/1. After the last command byte, `exec_start` pulses once and `exec_busy` stays high until `exec_done`, with status reading 0x00 OR bit 5 OR the seek flags.
- R8: `tc` during execution ends it like `exec_done`. `tc` during the command phase discards the partial command and returns to the ready-for-opcode state. `tc` in the result phase has no effect.
- R9: In the result phase the status reads 0xC0 OR the seek flags. Data reads return `res_byte` for `res_idx` 0 up to n-1, and writes are ignored. Status returns to 0x80 OR the seek flags after the last read.
- R10: An opcode not in the table yields exactly one result byte, 0x80, with no `exec_start`.
- R11: An opcode with zero result bytes returns to the ready-for-opcode state as soon as execution ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | 0 = status byte, 1 = data port |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data (0 when not reading) |
| drv_seek | input | 4 | Per-drive seek-busy flags shown in status |
| dma_off | input | 1 | Execution runs in non-DMA mode |
| tc | input | 1 | Terminal count / abort |
| exec_done | input | 1 | Execution engine finished |
| res_byte | input | 8 | Result byte selected by res_idx |
| par_we | output | 1 | Command byte valid pulse |
| par_idx | output | 4 | Index of the command byte |
| par_data | output | 8 | Command byte value |
| exec_start | output | 1 | One-clock pulse at execution start |
| exec_busy | output | 1 | Execution phase active |
| res_idx | output | 3 | Index of the result byte being offered |

## Verification
A wrong byte count or a lost state shows up at the next status poll, a few clocks later. The host sees ready=1 when it expects ready=0 (or the reverse), or sees the wrong direction. A miscounted result phase also changes the data read values or the final 0x80 status. Lost or duplicated parameter strobes show as a mismatch in `par_idx` in the clock after the write. Abort and ignored-access corner cases are followed at once by a status read that exposes any state change they caused.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;

    localparam int OP_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_CGAP,
        ST_EXEC,
        ST_RGAP,
        ST_RES,
        ST_IGAP
    } phase_t;

    typedef struct packed {
        logic       valid;
        logic [3:0] ncmd;
        logic [2:0] nres;
    } op_info_t;

    function automatic op_info_t op_lookup(input logic [OP_W-1:0] op);
        op_info_t r;
        r = '{valid: 1'b1, ncmd: 4'd1, nres: 3'd1};
        unique case (op)
            5'h06:   begin r.ncmd = 4'd9; r.nres = 3'd7; end
            5'h05:   begin r.ncmd = 4'd9; r.nres = 3'd7; end
            5'h0D:   begin r.ncmd = 4'd6; r.nres = 3'd7; end
            5'h0A:   begin r.ncmd = 4'd2; r.nres = 3'd7; end
            5'h03:   begin r.ncmd = 4'd3; r.nres = 3'd0; end
            5'h07:   begin r.ncmd = 4'd2; r.nres = 3'd0; end
            5'h0F:   begin r.ncmd = 4'd3; r.nres = 3'd0; end
            5'h08:   begin r.ncmd = 4'd1; r.nres = 3'd2; end
            5'h04:   begin r.ncmd = 4'd2; r.nres = 3'd1; end
            default: begin r.valid = 1'b0; r.ncmd = 4'd1; r.nres = 3'd1; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fdc_bus_decode.sv
module fdc_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic a0,
    output logic stat_rd,
    output logic data_rd,
    output logic rd_acc,
    output logic wr_acc
);
    logic sel;
    logic data_wr;
    logic rd_q;
    logic wr_q;

    assign sel     = ~cs_n;
    assign stat_rd = sel & ~rd_n & wr_n & ~a0;
    assign data_rd = sel & ~rd_n & wr_n & a0;
    assign data_wr = sel & rd_n & ~wr_n & a0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= data_rd;
            wr_q <= data_wr;
        end
    end

    // writes take effect on the leading edge, reads on the trailing edge
    assign wr_acc = data_wr & ~wr_q;
    assign rd_acc = rd_q & ~data_rd;
endmodule

// File: rtl/fdc_cmd_table.sv
module fdc_cmd_table
    import fdc_host_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_info_t        info
);
    assign info = op_lookup(opcode);
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
    import fdc_host_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int          NDRV     = 4,
    parameter int          IDX_W    = 4,
    parameter int          RIDX_W   = 3,
    parameter logic [7:0]  BAD_CODE = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              a0,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    input  logic [NDRV-1:0]   drv_seek,
    input  logic              dma_off,
    input  logic              tc,
    input  logic              exec_done,
    input  logic [DW-1:0]     res_byte,
    output logic              par_we,
    output logic [IDX_W-1:0]  par_idx,
    output logic [DW-1:0]     par_data,
    output logic              exec_start,
    output logic              exec_busy,
    output logic [RIDX_W-1:0] res_idx
);
    localparam int PAD_W = DW - 3 - NDRV;

    phase_t              state_q, state_d;
    op_info_t            info_q, info_new;
    logic [IDX_W-1:0]    bcnt_q;
    logic [RIDX_W-1:0]   rcnt_q;
    logic                stat_rd, data_rd, rd_acc, wr_acc;
    logic                rqm, dio, ndm;
    logic [DW-1:0]       msr;
    logic                last_res;

    fdc_bus_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .a0      (a0),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .rd_acc  (rd_acc),
        .wr_acc  (wr_acc)
    );

    fdc_cmd_table u_tab (
        .opcode (din[OP_W-1:0]),
        .info   (info_new)
    );

    assign last_res = (RIDX_W'(rcnt_q + 1'b1) == info_q.nres);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_acc) state_d = ST_CGAP;
            ST_CMD: begin
                if (tc)          state_d = ST_IGAP;
                else if (wr_acc) state_d = ST_CGAP;
            end
            ST_CGAP: begin
                if (tc)                               state_d = ST_IGAP;
                else if (bcnt_q != IDX_W'(info_q.ncmd)) state_d = ST_CMD;
                else if (!info_q.valid)               state_d = ST_RGAP;
                else                                  state_d = ST_EXEC;
            end
            ST_EXEC: begin
                if (tc || exec_done)
                    state_d = (info_q.nres != '0) ? ST_RGAP : ST_IGAP;
            end
            ST_RGAP: state_d = ST_RES;
            ST_RES:  if (rd_acc) state_d = last_res ? ST_IGAP : ST_RGAP;
            ST_IGAP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            info_q     <= '{valid: 1'b0, ncmd: 4'd1, nres: 3'd0};
            bcnt_q     <= '0;
            rcnt_q     <= '0;
            par_we     <= 1'b0;
            par_idx    <= '0;
            par_data   <= '0;
            exec_start <= 1'b0;
        end else begin
            state_q    <= state_d;
            par_we     <= 1'b0;
            exec_start <= (state_q == ST_CGAP) && (state_d == ST_EXEC);
            if (state_q == ST_IDLE && wr_acc) begin
                info_q   <= info_new;
                bcnt_q   <= IDX_W'(1);
                par_we   <= 1'b1;
                par_idx  <= '0;
                par_data <= din;
            end else if (state_q == ST_CMD && wr_acc && !tc) begin
                bcnt_q   <= bcnt_q + 1'b1;
                par_we   <= 1'b1;
                par_idx  <= bcnt_q;
                par_data <= din;
            end
            if (state_q == ST_IDLE)
                rcnt_q <= '0;
            else if (state_q == ST_RES && rd_acc)
                rcnt_q <= rcnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        rqm = 1'b0;
        dio = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CMD: rqm = 1'b1;
            ST_RES:          begin rqm = 1'b1; dio = 1'b1; end
            ST_RGAP:         dio = 1'b1;
            default:         ;
        endcase
    end

    assign ndm       = (state_q == ST_EXEC) && dma_off;
    assign exec_busy = (state_q == ST_EXEC);
    assign res_idx   = rcnt_q;

    always_comb begin
        msr = '0;
        msr[DW-1] = rqm;
        msr[DW-2] = dio;
        msr[DW-3] = ndm;
        for (int i = 0; i < NDRV; i++)
            msr[i] = drv_seek[i];
    end

    always_comb begin
        if (stat_rd)
            dout = msr;
        else if (data_rd && state_q == ST_RES)
            dout = info_q.valid ? res_byte : BAD_CODE;
        else
            dout = '0;
    end

    if (PAD_W < 0) begin : g_bad_width
        initial $error("status byte too narrow for drive count");
    end
endmodule

// File: rtl/fdc_host_seq_chk.sv
module fdc_host_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] msr,
    input logic       wr_acc,
    input logic       rd_acc,
    input logic       exec_busy,
    input logic       exec_start,
    input logic       tc
);
    // R5: ready drops after an accepted write
    a_r5_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && msr[7] && !msr[6] |=> !msr[7]);

    // R5: ready drops after a consumed result byte
    a_r5_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc && msr[7] && msr[6] |=> !msr[7]);

    // R6: direction steady while ready stays high
    a_r6_dio_steady: assert property (@(posedge clk) disable iff (!rst_n)
        msr[7] && $past(msr[7]) |-> msr[6] == $past(msr[6]));

    // R7: start pulse coincides with execution
    a_r7_start_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> exec_busy);

    // R7: no host handshake during execution
    a_r7_exec_no_rqm: assert property (@(posedge clk) disable iff (!rst_n)
        exec_busy |-> !msr[7] && !msr[6]);

    // R3: non-DMA flag only while executing
    a_r3_ndm_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        msr[5] |-> exec_busy);

    // R8: terminal count ends execution
    a_r8_tc_ends_exec: assert property (@(posedge clk) disable iff (!rst_n)
        exec_busy && tc |=> !exec_busy);
endmodule

bind fdc_host_seq fdc_host_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msr        (msr),
    .wr_acc     (wr_acc),
    .rd_acc     (rd_acc),
    .exec_busy  (exec_busy),
    .exec_start (exec_start),
    .tc         (tc)
);

// File: tb/fdc_host_seq_test.sv
module fdc_host_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [3:0] drv_seek = 4'h0;
    logic       dma_off = 1'b0;
    logic       tc = 1'b0;
    logic       exec_done = 1'b0;
    logic [7:0] res_byte;
    logic       par_we;
    logic [3:0] par_idx;
    logic [7:0] par_data;
    logic       exec_start, exec_busy;
    logic [2:0] res_idx;

    int errors = 0;
    int checks = 0;
    int starts = 0;
    int pwe    = 0;

    always #4 clk = ~clk;

    assign res_byte = 8'hA0 + {5'd0, res_idx};

    fdc_host_seq uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
        .din(din), .dout(dout), .drv_seek(drv_seek), .dma_off(dma_off), .tc(tc),
        .exec_done(exec_done), .res_byte(res_byte), .par_we(par_we), .par_idx(par_idx),
        .par_data(par_data), .exec_start(exec_start), .exec_busy(exec_busy), .res_idx(res_idx)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (exec_start) starts++;
            if (par_we) pwe++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit f_valid(input logic [4:0] op);
        return op inside {5'h06, 5'h05, 5'h0D, 5'h0A, 5'h03, 5'h07, 5'h0F, 5'h08, 5'h04};
    endfunction

    function automatic int f_ncmd(input logic [4:0] op);
        case (op)
            5'h06, 5'h05: return 9;
            5'h0D:        return 6;
            5'h03, 5'h0F: return 3;
            5'h0A, 5'h07, 5'h04: return 2;
            default:      return 1;
        endcase
    endfunction

    function automatic int f_nres(input logic [4:0] op);
        case (op)
            5'h06, 5'h05, 5'h0D, 5'h0A: return 7;
            5'h03, 5'h07, 5'h0F: return 0;
            5'h08: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [4:0] pick_op(input int k);
        case (k)
            0: return 5'h06; 1: return 5'h05; 2: return 5'h0D; 3: return 5'h0A;
            4: return 5'h03; 5: return 5'h07; 6: return 5'h0F; 7: return 5'h08;
            8: return 5'h04;
            default: return 5'($urandom);
        endcase
    endfunction

    task automatic bus(input logic c, input logic r, input logic w, input logic a,
                       input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        cs_n = c; rd_n = r; wr_n = w; a0 = a; din = d;
        @(negedge clk);
        @(negedge clk);
        q = dout;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; a0 = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd_stat(output logic [7:0] q);
        bus(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, q);
    endtask

    task automatic rd_data(output logic [7:0] q);
        bus(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, q);
    endtask

    task automatic wr_data(input logic [7:0] d);
        logic [7:0] q;
        bus(1'b0, 1'b1, 1'b0, 1'b1, d, q);
    endtask

    task automatic pulse(input bit use_tc);
        @(negedge clk);
        if (use_tc) tc = 1'b1; else exec_done = 1'b1;
        @(negedge clk);
        tc = 1'b0; exec_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [7:0] first, input bit use_tc);
        logic [4:0] op;
        logic [7:0] q, b;
        int n, nr, p0, s0;
        op = first[4:0];
        n  = f_ncmd(op);
        nr = f_nres(op);
        p0 = pwe;
        s0 = starts;
        for (int i = 0; i < n; i++) begin
            rd_stat(q);
            chk("R4 ready for command byte", q, {4'h8, drv_seek});
            b = (i == 0) ? first : 8'($urandom);
            wr_data(b);
            chk("R4 parameter strobe count", pwe, p0 + i + 1);
            chk("R4 parameter index", par_idx, i);
            chk("R4 parameter data", par_data, b);
        end
        if (f_valid(op)) begin
            chk("R7 exec busy", exec_busy, 1);
            chk("R7 one start pulse", starts, s0 + 1);
            rd_stat(q);
            chk("R3 status in execution", q, {2'b00, dma_off, 1'b0, drv_seek});
            pulse(use_tc);
            chk("R8 execution ended", exec_busy, 0);
            if (nr == 0) begin
                rd_stat(q);
                chk("R11 idle after no-result command", q, {4'h8, drv_seek});
            end
        end else begin
            chk("R10 no start for unknown opcode", starts, s0);
        end
        for (int j = 0; j < nr; j++) begin
            rd_stat(q);
            chk("R9 result status", q, {4'hC, drv_seek});
            rd_data(q);
            if (f_valid(op)) chk("R9 result byte", q, 8'hA0 + j);
            else             chk("R10 invalid code", q, 8'h80);
        end
        rd_stat(q);
        chk("R9 back to idle", q, {4'h8, drv_seek});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] q;
        int p0, s0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd_stat(q);
        chk("R2 reset status", q, 8'h80);
        drv_seek = 4'b1010;
        rd_stat(q);
        chk("R2 seek flags shown", q, 8'h8A);

        // R1 chip select high blocks a one-byte command
        p0 = pwe; s0 = starts;
        bus(1'b1, 1'b1, 1'b0, 1'b1, 8'h08, q);
        chk("R1 cs high write ignored", pwe, p0);
        chk("R1 cs high no exec", exec_busy, 0);
        // R1 write with a0=0 is illegal
        bus(1'b0, 1'b1, 1'b0, 1'b0, 8'h08, q);
        chk("R1 a0=0 write ignored", pwe, p0);
        // R1 both strobes low is illegal
        bus(1'b0, 1'b0, 1'b0, 1'b1, 8'h08, q);
        chk("R1 dual strobe ignored", pwe, p0);
        chk("R1 dual strobe no start", starts, s0);
        rd_stat(q);
        chk("R1 still idle", q, 8'h8A);

        // R8 abort in command phase
        wr_data(8'h46);
        rd_stat(q);
        chk("R8 mid command ready", q, 8'h8A);
        pulse(1'b1);
        rd_stat(q);
        chk("R8 abort returns idle", q, 8'h8A);
        p0 = pwe;
        wr_data(8'h08);
        chk("R8 fresh opcode index", par_idx, 0);
        chk("R8 fresh command starts", exec_busy, 1);
        pulse(1'b0);
        // R8 tc in result phase ignored, R9 writes ignored
        rd_data(q);
        chk("R9 first result", q, 8'hA0);
        pulse(1'b1);
        wr_data(8'h55);
        chk("R9 write in result ignored", pwe, p0 + 1);
        rd_stat(q);
        chk("R8 tc ignored in results", q, 8'hCA);
        rd_data(q);
        chk("R9 second result", q, 8'hA1);
        rd_stat(q);
        chk("R9 idle after last", q, 8'h8A);

        // R10 directed unknown opcode
        run_cmd(8'h1F, 1'b0);
        // R3 non-DMA flag
        dma_off = 1'b1;
        run_cmd(8'h03, 1'b0);

        for (int k = 0; k < 30; k++) begin
            drv_seek = 4'($urandom);
            dma_off  = 1'($urandom);
            run_cmd({3'($urandom), pick_op(int'($urandom % 11))}, 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule